// File: doc/BRIEF.md
# Panel Power and Reset Sequencer

This block brings a display panel from a fully unpowered state to a state where serial traffic may begin. When a start request arrives while the panel is off, it raises the external power enable and puts the data/command select and the active-low chip select at their idle high levels. It then holds the panel in reset while the supply settles. After that it produces a reset waveform with fixed millisecond spacing: release, assert, release again. A final settle interval follows, and then it reports the panel ready.

A stop request issued while the panel is ready runs the shutdown in two steps. The data/command select, reset and chip select fall first, and the power enable follows one millisecond later. All millisecond intervals come from a prescaler derived from the `CLK_HZ` parameter. A `done` pulse marks the end of both the power-up run and the power-down run. The state indicator lets a host controller see how far the sequence has progressed.

Top module: `panel_power_seq`

## Requirements
- R1: While reset is held, and in the off state, `pwr_en`, `panel_rst_n`, `dc_sel`, `cs_n`, `ready` and `done` are all 0 and `state` is 0 (off).
- R2: A `start` sampled in the off state moves the block on the next edge to `state` 1 (power wait), with `pwr_en`=1, `dc_sel`=1, `cs_n`=1 and `panel_rst_n`=0. It stays there for `T_PWR_MS` (200) ms.
- R3: After the power wait, `panel_rst_n` goes high for `T_RH_MS` (2) ms in `state` 2, with the other controls unchanged.
- R4: Next, `panel_rst_n` is driven low for `T_RL_MS` (4) ms in `state` 3.
- R5: Next, `panel_rst_n` returns high and the block waits `T_SET_MS` (20) ms in `state` 4.
- R6: After the settle wait the block enters `state` 5 (ready): `ready`=1 and all four controls are high. `done` is 1 for exactly the first cycle in that state.
- R7: `start` has no effect in any state other than off, and `stop` has no effect in any state other than ready.
- R8: A `stop` sampled in ready leads to `state` 6 for `T_OFF_MS` (1) ms. In that state `dc_sel`, `panel_rst_n` and `cs_n` are 0 while `pwr_en` stays 1. The block then returns to off with all outputs 0, and `done` is 1 for the first cycle there.
- R9: One millisecond is exactly `CLK_HZ/1000` clock cycles, so each interval lasts its length in ms times that count.
- R10: `start` and `stop` sampled together in the off state begin a power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Power-up request |
| stop | input | 1 | Power-down request |
| pwr_en | output | 1 | External power switch enable |
| panel_rst_n | output | 1 | Panel reset, active low |
| dc_sel | output | 1 | Data (1) / command (0) select |
| cs_n | output | 1 | Panel chip select, active low |
| ready | output | 1 | Panel powered and out of reset |
| done | output | 1 | One-cycle end-of-sequence pulse |
| state | output | 3 | Sequence position, codes as in R1 to R8 |

## Verification
A wrong state or a miscounted interval shows up at the ports as a control edge that arrives one or more cycles early or late. Each phase boundary is therefore checked on the exact cycle of the change and on the cycle before it, so a one-cycle error in the prescaler or in the interval counter is caught at the first boundary. A request that is wrongly accepted shows up within one cycle as a changed `state` or a dropped `pwr_en`. A misplaced `done` shows up at the ready or off transition.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_PWR_WAIT = 3'd1,
        PS_RST_HI   = 3'd2,
        PS_RST_LO   = 3'd3,
        PS_SETTLE   = 3'd4,
        PS_READY    = 3'd5,
        PS_PWR_DOWN = 3'd6
    } pseq_state_e;

    typedef struct packed {
        logic pwr_en;
        logic rst_n;
        logic dc;
        logic cs_n;
        logic ready;
    } panel_pins_t;

    function automatic panel_pins_t pins_for(pseq_state_e s);
        panel_pins_t p;
        p = '0;
        case (s)
            PS_PWR_WAIT: p = '{pwr_en: 1'b1, rst_n: 1'b0, dc: 1'b1, cs_n: 1'b1, ready: 1'b0};
            PS_RST_HI,
            PS_SETTLE:   p = '{pwr_en: 1'b1, rst_n: 1'b1, dc: 1'b1, cs_n: 1'b1, ready: 1'b0};
            PS_RST_LO:   p = '{pwr_en: 1'b1, rst_n: 1'b0, dc: 1'b1, cs_n: 1'b1, ready: 1'b0};
            PS_READY:    p = '{pwr_en: 1'b1, rst_n: 1'b1, dc: 1'b1, cs_n: 1'b1, ready: 1'b1};
            PS_PWR_DOWN: p = '{pwr_en: 1'b1, rst_n: 1'b0, dc: 1'b0, cs_n: 1'b0, ready: 1'b0};
            default:     p = '0;
        endcase
        return p;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/panel_seq_ms_tick.sv
module panel_seq_ms_tick #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/panel_seq_interval.sv
module panel_seq_interval #(
    parameter int MSW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [MSW-1:0] dur_ms,
    input  logic           tick,
    output logic           expire
);
    logic [MSW-1:0] ms_left;

    assign expire = tick && (ms_left == MSW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_left <= '0;
        end else if (load) begin
            ms_left <= dur_ms;
        end else if (tick && (ms_left != '0)) begin
            ms_left <= ms_left - 1'b1;
        end
    end
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
    import panel_seq_pkg::*;
#(
    parameter int CLK_HZ   = 100_000,
    parameter int T_PWR_MS = 200,
    parameter int T_RH_MS  = 2,
    parameter int T_RL_MS  = 4,
    parameter int T_SET_MS = 20,
    parameter int T_OFF_MS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       stop,
    output logic       pwr_en,
    output logic       panel_rst_n,
    output logic       dc_sel,
    output logic       cs_n,
    output logic       ready,
    output logic       done,
    output logic [2:0] state
);
    localparam int CYC    = CLK_HZ / 1000;
    localparam int MAX_MS = max_of(max_of(max_of(T_PWR_MS, T_RH_MS), max_of(T_RL_MS, T_SET_MS)), T_OFF_MS);
    localparam int MSW    = $clog2(MAX_MS + 1);

    pseq_state_e    st, nxt;
    logic           load, tick, expire, done_nxt;
    logic [MSW-1:0] dur;
    panel_pins_t    pins;

    panel_seq_ms_tick #(.CYC(CYC)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .tick  (tick)
    );

    panel_seq_interval #(.MSW(MSW)) u_ival (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .dur_ms (dur),
        .tick   (tick),
        .expire (expire)
    );

    always_comb begin
        nxt  = st;
        load = 1'b0;
        dur  = '0;
        case (st)
            PS_OFF: if (start) begin
                nxt = PS_PWR_WAIT; load = 1'b1; dur = MSW'(T_PWR_MS);
            end
            PS_PWR_WAIT: if (expire) begin
                nxt = PS_RST_HI; load = 1'b1; dur = MSW'(T_RH_MS);
            end
            PS_RST_HI: if (expire) begin
                nxt = PS_RST_LO; load = 1'b1; dur = MSW'(T_RL_MS);
            end
            PS_RST_LO: if (expire) begin
                nxt = PS_SETTLE; load = 1'b1; dur = MSW'(T_SET_MS);
            end
            PS_SETTLE: if (expire) begin
                nxt = PS_READY;
            end
            PS_READY: if (stop) begin
                nxt = PS_PWR_DOWN; load = 1'b1; dur = MSW'(T_OFF_MS);
            end
            PS_PWR_DOWN: if (expire) begin
                nxt = PS_OFF;
            end
            default: nxt = PS_OFF;
        endcase
    end

    assign done_nxt = ((st == PS_SETTLE) && (nxt == PS_READY)) ||
                      ((st == PS_PWR_DOWN) && (nxt == PS_OFF));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PS_OFF;
            done <= 1'b0;
        end else begin
            st   <= nxt;
            done <= done_nxt;
        end
    end

    assign pins        = pins_for(st);
    assign pwr_en      = pins.pwr_en;
    assign panel_rst_n = pins.rst_n;
    assign dc_sel      = pins.dc;
    assign cs_n        = pins.cs_n;
    assign ready       = pins.ready;
    assign state       = st;
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       stop,
    input logic       pwr_en,
    input logic       panel_rst_n,
    input logic       dc_sel,
    input logic       cs_n,
    input logic       ready,
    input logic       done,
    input logic [2:0] state
);
    // R1
    off_all_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> (!panel_rst_n && !dc_sel && !cs_n && !ready));

    // R2
    pwr_rise_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |-> (!panel_rst_n && dc_sel && cs_n));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    ready_levels_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pwr_en && panel_rst_n && dc_sel && cs_n));

    // R7
    start_ignored_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start && !stop) |=> ready);

    // R8
    pwr_fall_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> ($past(!panel_rst_n) && $past(!dc_sel) && $past(!cs_n)));

    // R8
    state_legal_chk: assert property (@(posedge clk) disable iff (rst)
        state <= 3'd6);
endmodule

bind panel_power_seq panel_seq_chk u_chk (.*);

// File: tb/test_panel_power_seq.sv
module test_panel_power_seq;
    localparam int C = 100;  // cycles per ms for CLK_HZ = 100_000

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       pwr_en, panel_rst_n, dc_sel, cs_n, ready, done;
    logic [2:0] state;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        int         at;
        logic [2:0] st;
        logic       dn;
        string      req;
    } exp_t;

    exp_t q[$];

    panel_power_seq i_panel_power_seq (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .pwr_en(pwr_en), .panel_rst_n(panel_rst_n), .dc_sel(dc_sel),
        .cs_n(cs_n), .ready(ready), .done(done), .state(state)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // expected {pwr_en, rst_n, dc, cs_n, ready} per state code from R1..R8
    function automatic logic [4:0] exp_pins(logic [2:0] s);
        case (s)
            3'd1:    return 5'b10110;
            3'd2:    return 5'b11110;
            3'd3:    return 5'b10110;
            3'd4:    return 5'b11110;
            3'd5:    return 5'b11111;
            3'd6:    return 5'b10000;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic push(int at, logic [2:0] st, logic dn, string req);
        exp_t e;
        e.at = at; e.st = st; e.dn = dn; e.req = req;
        q.push_back(e);
    endtask

    // monitor / scoreboard
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) begin
                n_run++; n_fail++;
                $display("FAIL R6 done high two cycles at %0d: actual 1 expected 0", cyc);
            end
            prev_done <= done;
            while (q.size() > 0 && q[0].at < cyc) begin
                n_run++; n_fail++;
                $display("FAIL %s item for cycle %0d missed: actual none expected checked", q[0].req, q[0].at);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].at == cyc) begin
                logic [8:0] act, expv;
                act  = {pwr_en, panel_rst_n, dc_sel, cs_n, ready, done, state};
                expv = {exp_pins(q[0].st), q[0].dn, q[0].st};
                n_run++;
                if (act !== expv) begin
                    n_fail++;
                    $display("FAIL %s at cycle %0d: actual %b expected %b", q[0].req, cyc, act, expv);
                end
                void'(q.pop_front());
            end
        end
    end

    task automatic wait_cyc(int target);
        while (cyc < target) @(negedge clk);
    endtask

    // power-up run; with_stop exercises R10
    task automatic power_up(bit with_stop, bit glitch);
        int n, t1, t2, t3, t4;
        @(negedge clk);
        n  = cyc;
        t1 = n + 1 + 200 * C;   // R9: 200 ms
        t2 = t1 + 2 * C;
        t3 = t2 + 4 * C;
        t4 = t3 + 20 * C;
        push(n + 1,  3'd1, 1'b0, with_stop ? "R10" : "R2");
        push(t1 - 1, 3'd1, 1'b0, "R9");
        push(t1,     3'd2, 1'b0, "R3");
        push(t2 - 1, 3'd2, 1'b0, "R3");
        push(t2,     3'd3, 1'b0, "R4");
        push(t3 - 1, 3'd3, 1'b0, "R4");
        push(t3,     3'd4, 1'b0, "R5");
        push(t4 - 1, 3'd4, 1'b0, "R5");
        push(t4,     3'd5, 1'b1, "R6");
        push(t4 + 1, 3'd5, 1'b0, "R6");
        start = 1'b1;
        stop  = with_stop;
        @(negedge clk);
        start = 1'b0;
        stop  = 1'b0;
        if (glitch) begin
            // R7: requests during power wait and during reset low are ignored
            wait_cyc(n + 50);
            start = 1'b1; stop = 1'b1;
            @(negedge clk);
            start = 1'b0; stop = 1'b0;
            wait_cyc(t2 + 10);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cyc(t4 + 3);
    endtask

    task automatic power_down();
        int n;
        @(negedge clk);
        n = cyc;
        push(n + 1,         3'd6, 1'b0, "R8");
        push(n + C,         3'd6, 1'b0, "R8");
        push(n + 1 + C,     3'd0, 1'b1, "R8");
        push(n + 2 + C,     3'd0, 1'b0, "R8");
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        wait_cyc(n + C + 5);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        n_run++;
        if ({pwr_en, panel_rst_n, dc_sel, cs_n, ready, done, state} !== 9'b0) begin
            n_fail++;
            $display("FAIL R1 during reset: actual %b expected 0", {pwr_en, panel_rst_n, dc_sel, cs_n, ready, done, state});
        end
        rst = 1'b0;
        @(negedge clk);
        n = cyc;
        push(n + 1, 3'd0, 1'b0, "R1");
        // R7: stop in off is ignored
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        push(cyc + 1, 3'd0, 1'b0, "R7");
        wait_cyc(cyc + 3);

        power_up(1'b0, 1'b1);
        // R7: start in ready is ignored
        @(negedge clk);
        push(cyc + 1, 3'd5, 1'b0, "R7");
        push(cyc + 5, 3'd5, 1'b0, "R7");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc(cyc + 8);

        power_down();
        power_up(1'b1, 1'b0);
        power_down();

        wait_cyc(cyc + 5);
        if (q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R9 %0d items unchecked: actual %0d expected 0", q.size(), q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 150_000);
        n_run++; n_fail++;
        $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule